// File: doc/BRIEF.md
# UART FIFO Trigger Interrupt Controller

This block holds the transmit and receive character queues of a UART-style peripheral, each 128 characters deep and 8 bits wide, under an 8-bit FIFO control register. The host fills the transmit queue and drains the receive queue through single-cycle strobes. The serial side pops transmit characters and pushes received ones through a similar pair of strobes. A control write can enable the queues, flush either queue, pick a transfer-request mode and choose a trigger threshold for each direction.

From the occupancy of each queue the block produces a transmit-level interrupt, a receive-level interrupt and two transfer-ready indications. The ready indications are either plain occupancy flags or hysteretic requests sized for burst transfers, depending on the mode bit. Each queue also keeps a sticky overflow flag. A host that writes a full queue loses the character, and the flag records the loss.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both counts are 0, the control readback is 0x00, both overflow flags are 0, the transmit interrupt is 1, the receive interrupt is 0, transmit-ready is 1 and receive-ready is 0.
- R2: Each queue returns characters in the order they were written. A read or pop of an empty queue returns 0 and leaves the count at 0.
- R3: A write into a full queue (count 128) is dropped. The count stays at 128 and that queue's overflow flag goes to 1. The flag stays at 1 until that queue is flushed.
- R4: A control write with bit 0 = 1 and bit 2 = 1 empties the transmit queue and clears its overflow flag from the next cycle on. The receive queue and its flag are left untouched.
- R5: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue and clears its overflow flag. The transmit queue is left untouched.
- R6: A control write with bit 0 = 0 empties both queues. While the stored bit 0 is 0, both effective trigger levels are 1, whatever the stored trigger codes are.
- R7: The control readback is {rx_code[7:6], tx_code[5:4], dma[3], 0, 0, enable[0]}. The flush bits 2:1 always read as 0.
- R8: Bits 5:4 (the transmit trigger code) are stored only when feat_en is 1 during the write, and are otherwise kept. Transmit codes 0/1/2/3 select levels 1/32/64/112.
- R9: Bits 7:6 (the receive trigger code) select levels 1/32/64/120. The receive interrupt is 1 exactly when the receive count is at or above the level.
- R10: A transmit "armed" state is set at a clock edge where the transmit count exceeds the level, and is cleared at an edge where the count is 0 or by a flush. While armed, the transmit interrupt is (count < level). While not armed, it is (count == 0).
- R11: With bit 3 = 0, receive-ready is (count != 0). With bit 3 = 1, it rises when the count reaches the receive level, or when rx_timeout is 1 with a non-empty queue. It then holds until the queue is empty.
- R12: With bit 3 = 0, transmit-ready is (count != 128). With bit 3 = 1, it rises when the count is below the transmit level and holds until the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcr_wr | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write value |
| feat_en | input | 1 | Enables writing of the transmit trigger code |
| fcr_rdata | output | 8 | Control register readback |
| tx_wr | input | 1 | Host writes one transmit character |
| tx_wdata | input | 8 | Transmit character from host |
| tx_pop | input | 1 | Serial side takes the head transmit character |
| tx_pop_data | output | 8 | Head of transmit queue, 0 when empty |
| tx_count | output | 8 | Transmit occupancy 0..128 |
| tx_overflow | output | 1 | Sticky transmit overflow flag |
| tx_level_irq | output | 1 | Transmit-level interrupt request |
| tx_ready | output | 1 | Transmit transfer-ready indication |
| rx_push | input | 1 | Serial side delivers one character |
| rx_push_data | input | 8 | Received character |
| rx_rd | input | 1 | Host reads the head receive character |
| rx_rdata | output | 8 | Head of receive queue, 0 when empty |
| rx_count | output | 8 | Receive occupancy 0..128 |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| rx_level_irq | output | 1 | Receive-level interrupt request |
| rx_ready | output | 1 | Receive transfer-ready indication |
| rx_timeout | input | 1 | Receive timeout indication from the line side |

## Verification
The case that is hardest to reach is the difference between the two transmit interrupt rules. It only shows after a refill has passed the threshold, and it has to be told apart from a refill that stopped at the threshold. For every transmit code, the bench refills exactly to the level and drains to empty, then refills to one above the level and drains again. It checks the interrupt after each character against an arithmetic model of the armed state. The hysteretic ready outputs are driven to their far end (a full transmit queue, an emptied receive queue) so that the hold is seen to release, and a timeout pulse below the receive level is also applied.

// File: rtl/uft_pkg.sv
// Package: shared control-register layout and trigger-code decoding for the
// UART FIFO trigger controller. Assumes 2-bit trigger codes.
package uft_pkg;

    // Stored control fields (flush bits are not stored).
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       dma;
        logic       en;
    } uft_cfg_t;

    // Maps a 2-bit trigger code onto a level; code 0 always means 1.
    function automatic int unsigned code_to_level(input logic [1:0] code,
                                                  input int unsigned lvl1,
                                                  input int unsigned lvl2,
                                                  input int unsigned lvl3);
        case (code)
            2'd1:    return lvl1;
            2'd2:    return lvl2;
            2'd3:    return lvl3;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/uft_fifo.sv
// Module: circular character queue with occupancy count and sticky overflow.
// Assumes: one push and one pop per cycle at most; clr has priority over both;
// the storage array is not reset, only pointers, count and flag are.
module uft_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              empty;
    logic              do_push;
    logic              do_pop;

    // Advances a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Qualifies the strobes against occupancy and the flush.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
    end

    // Stores an accepted character at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Moves pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)      count <= count + CNT_W'(1);
            else if (do_pop && !do_push) count <= count - CNT_W'(1);
        end
    end

    // Records a dropped write until the next flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) overflow <= 1'b0;
        else if (push && full) overflow <= 1'b1;
    end

    // Presents the head character, or zero when empty.
    assign pop_data = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/uft_ctrl.sv
// Module: FIFO control register. Decodes writes into stored fields, flush
// pulses and effective trigger levels. Assumes flush pulses act in the
// write cycle, so the flush bits never need storage and read back as 0.
module uft_ctrl
    import uft_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int TX_LVL_1 = 32,
    parameter int TX_LVL_2 = 64,
    parameter int TX_LVL_3 = 112,
    parameter int RX_LVL_1 = 32,
    parameter int RX_LVL_2 = 64,
    parameter int RX_LVL_3 = 120,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             feat_en,
    output uft_cfg_t         cfg,
    output logic             tx_clr,
    output logic             rx_clr,
    output logic [CNT_W-1:0] tx_level,
    output logic [CNT_W-1:0] rx_level,
    output logic [7:0]       rdata
);

    // Updates stored fields; the transmit code needs the feature enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.en      <= wdata[0];
            cfg.dma     <= wdata[3];
            cfg.rx_code <= wdata[7:6];
            if (feat_en) cfg.tx_code <= wdata[5:4];
        end
    end

    // Derives flush pulses; disabling the queues flushes both.
    always_comb begin
        tx_clr = wr && (!wdata[0] || wdata[2]);
        rx_clr = wr && (!wdata[0] || wdata[1]);
    end

    // Selects effective levels; a disabled block uses level 1.
    always_comb begin
        tx_level = cfg.en ? CNT_W'(code_to_level(cfg.tx_code, TX_LVL_1, TX_LVL_2, TX_LVL_3))
                          : CNT_W'(1);
        rx_level = cfg.en ? CNT_W'(code_to_level(cfg.rx_code, RX_LVL_1, RX_LVL_2, RX_LVL_3))
                          : CNT_W'(1);
    end

    assign rdata = {cfg.rx_code, cfg.tx_code, cfg.dma, 2'b00, cfg.en};

endmodule

// File: rtl/uft_tx_flow.sv
// Module: transmit interrupt and transfer-ready generation from occupancy.
// Assumes count moves by at most one per cycle, so a registered armed state
// lagging one edge never misses the crossing below the level.
module uft_tx_flow #(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             dma,
    input  logic             full,
    output logic             irq,
    output logic             ready
);

    logic armed;
    logic hold;
    logic below;

    assign below = (count < level);

    // Remembers whether the last refill went above the level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      armed <= 1'b0;
        else if (count > level) armed <= 1'b1;
        else if (count == '0)   armed <= 1'b0;
    end

    // Holds the burst request from below-level until full.
    always_ff @(posedge clk) begin
        if (!rst_n) hold <= 1'b0;
        else        hold <= !full && (hold || below);
    end

    // Chooses the interrupt rule and the ready mode.
    always_comb begin
        irq   = armed ? below : (count == '0);
        ready = dma ? (!full && (hold || below)) : !full;
    end

endmodule

// File: rtl/uft_rx_flow.sv
// Module: receive interrupt and transfer-ready generation from occupancy.
// Assumes the timeout input is only meaningful with a non-empty queue.
module uft_rx_flow #(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             dma,
    input  logic             timeout,
    output logic             irq,
    output logic             ready
);

    logic hold;
    logic nonempty;
    logic start;

    // Computes occupancy conditions.
    always_comb begin
        nonempty = (count != '0);
        irq      = (count >= level);
        start    = irq || (timeout && nonempty);
    end

    // Holds the burst request until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n) hold <= 1'b0;
        else        hold <= nonempty && (hold || start);
    end

    // Selects plain or burst ready behaviour.
    assign ready = dma ? (nonempty && (hold || start)) : nonempty;

endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
// Module: top of the UART FIFO trigger controller. Ties the control register
// to two queues and their interrupt and ready logic. Assumes the host and
// serial strobes are single-cycle and synchronous to clk.
module uart_fifo_trig_ctrl
    import uft_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 128,
    parameter int TX_LVL_1 = 32,
    parameter int TX_LVL_2 = 64,
    parameter int TX_LVL_3 = 112,
    parameter int RX_LVL_1 = 32,
    parameter int RX_LVL_2 = 64,
    parameter int RX_LVL_3 = 120,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fcr_wr,
    input  logic [7:0]        fcr_wdata,
    input  logic              feat_en,
    output logic [7:0]        fcr_rdata,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_overflow,
    output logic              tx_level_irq,
    output logic              tx_ready,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_overflow,
    output logic              rx_level_irq,
    output logic              rx_ready,
    input  logic              rx_timeout
);

    uft_cfg_t         cfg;
    logic             tx_clr;
    logic             rx_clr;
    logic [CNT_W-1:0] tx_level;
    logic [CNT_W-1:0] rx_level;
    logic             tx_full;
    logic             rx_full;

    uft_ctrl #(
        .DEPTH(DEPTH),
        .TX_LVL_1(TX_LVL_1), .TX_LVL_2(TX_LVL_2), .TX_LVL_3(TX_LVL_3),
        .RX_LVL_1(RX_LVL_1), .RX_LVL_2(RX_LVL_2), .RX_LVL_3(RX_LVL_3)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .wdata(fcr_wdata),
        .feat_en(feat_en), .cfg(cfg), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_level(tx_level), .rx_level(rx_level), .rdata(fcr_rdata)
    );

    uft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_wr), .push_data(tx_wdata),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .count(tx_count), .full(tx_full), .overflow(tx_overflow)
    );

    uft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_rd), .pop_data(rx_rdata),
        .count(rx_count), .full(rx_full), .overflow(rx_overflow)
    );

    uft_tx_flow #(.DEPTH(DEPTH)) u_tx_flow (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .count(tx_count), .level(tx_level), .dma(cfg.dma), .full(tx_full),
        .irq(tx_level_irq), .ready(tx_ready)
    );

    uft_rx_flow #(.DEPTH(DEPTH)) u_rx_flow (
        .clk(clk), .rst_n(rst_n),
        .count(rx_count), .level(rx_level), .dma(cfg.dma), .timeout(rx_timeout),
        .irq(rx_level_irq), .ready(rx_ready)
    );

    // The receive full flag has no consumer at this level; it only feeds the queue.
    logic unused_rx_full;
    assign unused_rx_full = rx_full;

endmodule

// File: rtl/uart_fifo_trig_ctrl_chk.sv
// Module: property checker for the UART FIFO trigger controller, bound to
// the top. Observes ports only.
module uart_fifo_trig_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fcr_wr,
    input logic [7:0]        fcr_wdata,
    input logic [7:0]        fcr_rdata,
    input logic              tx_wr,
    input logic              tx_pop,
    input logic [CNT_W-1:0]  tx_count,
    input logic              tx_overflow,
    input logic              tx_level_irq,
    input logic              rx_push,
    input logic              rx_rd,
    input logic [DATA_W-1:0] rx_rdata,
    input logic [CNT_W-1:0]  rx_count,
    input logic              rx_ready
);

    a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_pop && !fcr_wr && tx_count == CNT_W'(DEPTH))
        |=> (tx_count == CNT_W'(DEPTH) && tx_overflow));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH) && rx_count <= CNT_W'(DEPTH)));

    a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (rx_rdata == '0));

    a_r2_empty_read_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_push && !fcr_wr && rx_count == '0) |=> (rx_count == '0));

    a_r6_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && !fcr_wdata[0]) |=> (tx_count == '0 && rx_count == '0));

    a_r4_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[0] && fcr_wdata[2]) |=> (tx_count == '0 && !tx_overflow));

    a_r10_empty_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_level_irq);

    a_r11_plain_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!fcr_rdata[3]) |-> (rx_ready == (rx_count != '0)));

endmodule

bind uart_fifo_trig_ctrl uart_fifo_trig_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
    .fcr_rdata(fcr_rdata), .tx_wr(tx_wr), .tx_pop(tx_pop), .tx_count(tx_count),
    .tx_overflow(tx_overflow), .tx_level_irq(tx_level_irq), .rx_push(rx_push),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_count(rx_count), .rx_ready(rx_ready)
);

// File: tb/uart_fifo_trig_ctrl_tb.sv
// Bench: sweeps occupancy for every trigger code in both directions against
// arithmetic expectations; drives inputs 2 ns after the rising edge.
module uart_fifo_trig_ctrl_tb;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       feat_en = 1'b0;
    logic [7:0] fcr_rdata;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_pop_data;
    logic [7:0] tx_count;
    logic       tx_overflow, tx_level_irq, tx_ready;
    logic       rx_push = 1'b0;
    logic [7:0] rx_push_data = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_rdata;
    logic [7:0] rx_count;
    logic       rx_overflow, rx_level_irq, rx_ready;
    logic       rx_timeout = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_fifo_trig_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .feat_en(feat_en), .fcr_rdata(fcr_rdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .tx_count(tx_count), .tx_overflow(tx_overflow), .tx_level_irq(tx_level_irq),
        .tx_ready(tx_ready), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_count(rx_count),
        .rx_overflow(rx_overflow), .rx_level_irq(rx_level_irq), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout)
    );

    function automatic int tx_lvl(input int c);
        return (c == 0) ? 1 : (c == 1) ? 32 : (c == 2) ? 64 : 112;
    endfunction

    function automatic int rx_lvl(input int c);
        return (c == 0) ? 1 : (c == 1) ? 32 : (c == 2) ? 64 : 120;
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic fcr(input logic [7:0] v, input logic fe);
        fcr_wdata = v; feat_en = fe; fcr_wr = 1'b1;
        tick();
        fcr_wr = 1'b0;
    endtask

    task automatic rxp(input logic [7:0] d);
        rx_push = 1'b1; rx_push_data = d;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic rxr();
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    task automatic txw(input logic [7:0] d);
        tx_wr = 1'b1; tx_wdata = d;
        tick();
        tx_wr = 1'b0;
    endtask

    task automatic txp();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        end
    endtask

    // Watchdog: counts as a failed check.
    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int armed;
        int cnt;
        int lvl;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 tx_count", int'(tx_count), 0);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 readback", int'(fcr_rdata), 0);
        chk("R1 overflow", int'({tx_overflow, rx_overflow}), 0);
        chk("R1 tx_irq", int'(tx_level_irq), 1);
        chk("R1 rx_irq", int'(rx_level_irq), 0);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 rx_ready", int'(rx_ready), 0);

        fcr(8'h01, 1'b0);

        // R2/R3 receive fill, overflow, drain in order
        for (int i = 0; i < DEPTH; i++) rxp(pat(i));
        chk("R3 rx full count", int'(rx_count), DEPTH);
        rxp(8'hAA);
        chk("R3 rx count after drop", int'(rx_count), DEPTH);
        chk("R3 rx overflow", int'(rx_overflow), 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 rx order", int'(rx_rdata), int'(pat(i)));
            rxr();
        end
        chk("R2 rx empty data", int'(rx_rdata), 0);
        rxr();
        chk("R2 rx empty count", int'(rx_count), 0);
        chk("R3 rx overflow sticky", int'(rx_overflow), 1);

        // R2/R3 transmit fill, overflow, drain in order
        for (int i = 0; i < DEPTH; i++) txw(pat(i + 7));
        txw(8'h55);
        chk("R3 tx count after drop", int'(tx_count), DEPTH);
        chk("R3 tx overflow", int'(tx_overflow), 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 tx order", int'(tx_pop_data), int'(pat(i + 7)));
            txp();
        end
        txp();
        chk("R2 tx empty count", int'(tx_count), 0);
        chk("R2 tx empty data", int'(tx_pop_data), 0);

        // R4 transmit flush leaves receive alone
        rxp(8'h11); rxp(8'h22); rxp(8'h33);
        txw(8'h44); txw(8'h45);
        fcr(8'h05, 1'b0);
        chk("R4 tx flushed", int'(tx_count), 0);
        chk("R4 tx overflow cleared", int'(tx_overflow), 0);
        chk("R4 rx kept", int'(rx_count), 3);
        chk("R4 rx overflow kept", int'(rx_overflow), 1);
        chk("R4 rx head kept", int'(rx_rdata), 8'h11);

        // R5 receive flush leaves transmit alone
        txw(8'h66);
        fcr(8'h03, 1'b0);
        chk("R5 rx flushed", int'(rx_count), 0);
        chk("R5 rx overflow cleared", int'(rx_overflow), 0);
        chk("R5 tx kept", int'(tx_count), 1);
        chk("R5 tx head kept", int'(tx_pop_data), 8'h66);

        // R7/R8 readback and feature-enable gating
        fcr(8'hFF, 1'b1);
        chk("R7 readback all ones", int'(fcr_rdata), 8'hF9);
        fcr(8'h01, 1'b0);
        chk("R8 tx code kept", int'(fcr_rdata), 8'h31);
        fcr(8'h01, 1'b1);
        chk("R8 tx code written", int'(fcr_rdata), 8'h01);
        fcr(8'h21, 1'b0);
        chk("R8 tx code ignored", int'(fcr_rdata), 8'h01);

        // R9 receive level sweep for every code
        for (int c = 0; c < 4; c++) begin
            fcr(8'((c << 6) | 8'h03), 1'b0);
            chk("R9 rx irq empty", int'(rx_level_irq), 0);
            for (int k = 1; k <= DEPTH; k++) begin
                rxp(pat(k));
                chk("R9 rx irq", int'(rx_level_irq), (k >= rx_lvl(c)) ? 1 : 0);
                chk("R11 rx ready plain", int'(rx_ready), 1);
            end
        end

        // R10 transmit interrupt: refill to level, then to level+1
        for (int c = 0; c < 4; c++) begin
            fcr(8'((c << 4) | 8'h05), 1'b1);
            lvl = tx_lvl(c);
            armed = 0; cnt = 0;
            chk("R10 tx irq after flush", int'(tx_level_irq), 1);
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k < lvl + pass; k++) begin
                    if (cnt > lvl) armed = 1; else if (cnt == 0) armed = 0;
                    txw(pat(k));
                    cnt++;
                    chk("R10 tx irq fill", int'(tx_level_irq), armed ? int'(cnt < lvl) : int'(cnt == 0));
                    chk("R12 tx ready plain", int'(tx_ready), (cnt != DEPTH) ? 1 : 0);
                end
                while (cnt > 0) begin
                    if (cnt > lvl) armed = 1; else if (cnt == 0) armed = 0;
                    txp();
                    cnt--;
                    chk("R10 tx irq drain", int'(tx_level_irq), armed ? int'(cnt < lvl) : int'(cnt == 0));
                end
            end
        end

        // R6 disabling flushes both and forces level 1
        rxp(8'h01); txw(8'h02);
        fcr(8'hC8, 1'b0);
        chk("R6 rx flushed", int'(rx_count), 0);
        chk("R6 tx flushed", int'(tx_count), 0);
        chk("R7 readback disabled", int'(fcr_rdata), 8'hF8);
        rxp(8'h03);
        chk("R6 rx level forced 1", int'(rx_level_irq), 1);
        chk("R11 dma ready at forced level", int'(rx_ready), 1);

        // R11 receive DMA mode with level 64 and timeout
        fcr(8'h8B, 1'b0);
        for (int k = 1; k <= 63; k++) begin
            rxp(pat(k));
            if (k == 1 || k == 63) chk("R11 rx dma below level", int'(rx_ready), 0);
        end
        rx_timeout = 1'b1;
        #1;
        chk("R11 rx dma timeout", int'(rx_ready), 1);
        tick();
        rx_timeout = 1'b0;
        #1;
        chk("R11 rx dma hold", int'(rx_ready), 1);
        for (int k = 0; k < 62; k++) rxr();
        chk("R11 rx dma hold at one", int'(rx_ready), 1);
        rxr();
        chk("R11 rx dma released", int'(rx_ready), 0);
        rx_timeout = 1'b1;
        tick();
        chk("R11 rx timeout on empty", int'(rx_ready), 0);
        rx_timeout = 1'b0;
        for (int k = 1; k <= 64; k++) begin
            rxp(pat(k));
            chk("R11 rx dma level", int'(rx_ready), (k >= 64) ? 1 : 0);
        end
        fcr(8'h81, 1'b0);
        chk("R11 rx plain again", int'(rx_ready), 1);

        // R12 transmit DMA mode with level 32
        fcr(8'h1D, 1'b1);
        chk("R12 tx dma empty", int'(tx_ready), 1);
        for (int k = 1; k <= DEPTH; k++) begin
            txw(pat(k));
            chk("R12 tx dma fill", int'(tx_ready), (k < DEPTH) ? 1 : 0);
        end
        for (int k = DEPTH - 1; k >= 0; k--) begin
            txp();
            chk("R12 tx dma drain", int'(tx_ready), (k < 32) ? 1 : 0);
        end

        summary();
        $finish;
    end

endmodule